// File: doc/BRIEF.md
# Register-Controlled Clock Source Selector

This block drives one output clock from one of several parent clocks. The choice comes from a bit field inside a 32-bit control register, which a synchronous write port updates on the system clock. Parameters set the position and width of the field, and they set how the field value maps to a parent. There are four mappings: a plain index counted from zero, an index counted from one, a single set bit whose position names the parent, and a per-parent table of field values.

When the write-mask convention is enabled, the upper half of each write word acts as a per-bit enable for the lower half. The upper half of the register then always reads as zero. A field value that names no parent is stored in the register but does not change the selection, and it raises an error flag that stays set until reset.

Changing the source never cuts a short pulse on the output. The old source is turned off while its clock is low, after two of its own falling edges. The new source is turned on after two falling edges of the new clock, and only once no other source is still enabled. A busy output is high from the write that asks for a new parent until the system-clock domain sees that the new parent is enabled.

Top module: `clksel_top`

## Requirements
- R1: After reset the register reads 0, the selected index is 0, busy and the error flag are low, and the output follows parent 0.
- R2: The selector field sits at parameter `FIELD_LSB` with width `FIELD_W`. In the index mode (`ENC_INDEX0`), field value k selects parent k for k < `NUM_SRC`.
- R3: The selection changes only on the clock edge that captures a write of a decodable value. The register value is read back on `regData` from the cycle after the write.
- R4: In the one-based mode (`ENC_INDEX1`), field value k selects parent k-1 for 1 <= k <= `NUM_SRC`. Field value 0 is invalid.
- R5: With `HIWORD_MASK`=1, bit 16+i of a write enables the write of bit i for i in 0..15. A bit whose enable is 0 keeps its value, and bits 31:16 read as 0. With `HIWORD_MASK`=0, all 32 bits are written.
- R6: In the one-hot mode (`ENC_ONEHOT`), a field with exactly one set bit at position p selects parent p. A field with zero or several set bits is invalid.
- R7: A write whose field value is invalid stores the value but keeps the previous selection. It sets `selErr`, which stays high until reset.
- R8: At most one parent is enabled at any time. No pulse on `clkOut` is shorter than the shortest half period of the parents involved.
- R9: Once a switch has completed, `clkOut` runs at the period of the selected parent.
- R10: `busy` is high in the cycle after a write that changes the selected index and stays high until the switch completes. A write that keeps the current index leaves `busy` low.
- R11: In the table mode (`ENC_TABLE`), entry i of `MAP` (bits i*`FIELD_W` upward) is the field value for parent i. If several entries match, the lowest parent index wins. A value that matches no entry is invalid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock for the register and the write port |
| rstN | input | 1 | Asynchronous active-low reset |
| srcClk | input | NUM_SRC | Parent clocks, bit i is parent i |
| wrEn | input | 1 | Write strobe for the control register |
| wrData | input | 32 | Write word (with the upper half used as a bit enable in mask mode) |
| regData | output | 32 | Current register contents |
| selIdx | output | IDX_W | Decoded index of the selected parent |
| busy | output | 1 | A switchover is in progress |
| selErr | output | 1 | Sticky flag set by an undecodable field value |
| clkOut | output | 1 | Selected clock |

## Verification
`regData`, `selIdx` and `selErr` change on the rising edge that captures the write. `busy` rises combinationally from that same edge. The bench drives each write across one falling-to-falling window and samples all four at the falling edge that ends the window. Switch completion takes a number of cycles that depends on the two parent periods, so the bench polls `busy` on falling edges with a bounded limit. Only after `busy` falls does it time two rising edges of `clkOut` against the selected parent's period. Pulse widths on `clkOut` are monitored during the whole run, and a sweep over every field value of four small configurations (one per encoding) compares each result with an arithmetic decode done in the bench.

// File: rtl/clksel_pkg.sv
`timescale 1ns/1ps
package clksel_pkg;

  // Field encodings for the selector value
  typedef enum logic [1:0] {
    ENC_INDEX0 = 2'd0,
    ENC_INDEX1 = 2'd1,
    ENC_ONEHOT = 2'd2,
    ENC_TABLE  = 2'd3
  } enc_e;

  localparam int MAX_SRC = 16;

  // Strobes from control to the switching datapath
  typedef struct packed {
    logic [MAX_SRC-1:0] want;   // one-hot requested parent
  } swCmd_t;

endpackage

// File: rtl/clksel_decode.sv
`timescale 1ns/1ps
module clksel_decode #(
  parameter int NUM_SRC = 4,
  parameter int FIELD_W = 2,
  parameter int IDX_W = 2,
  parameter clksel_pkg::enc_e ENC = clksel_pkg::ENC_INDEX0,
  parameter logic [NUM_SRC*FIELD_W-1:0] MAP = '0
) (
  input  logic [FIELD_W-1:0] field,
  output logic               hit,
  output logic [IDX_W-1:0]   idx
);

  generate
    if (ENC == clksel_pkg::ENC_INDEX0) begin : g_idx0
      always_comb begin
        hit = 32'(field) < NUM_SRC;
        idx = IDX_W'(field);
      end
    end else if (ENC == clksel_pkg::ENC_INDEX1) begin : g_idx1
      always_comb begin
        hit = (field != '0) && (32'(field) <= NUM_SRC);
        idx = IDX_W'(field - FIELD_W'(1));
      end
    end else if (ENC == clksel_pkg::ENC_ONEHOT) begin : g_hot
      int pos;
      always_comb begin
        pos = 0;
        for (int i = 0; i < FIELD_W; i++) begin
          if (field[i]) pos = i;
        end
        hit = ($countones(field) == 1) && (pos < NUM_SRC);
        idx = IDX_W'(pos);
      end
    end else begin : g_tab
      always_comb begin
        hit = 1'b0;
        idx = '0;
        // scan downward so the lowest matching parent is kept
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
          if (field == MAP[i*FIELD_W +: FIELD_W]) begin
            hit = 1'b1;
            idx = IDX_W'(i);
          end
        end
      end
    end
  endgenerate

endmodule

// File: rtl/clksel_ctrl.sv
`timescale 1ns/1ps
module clksel_ctrl #(
  parameter int NUM_SRC = 4,
  parameter int FIELD_LSB = 14,
  parameter int FIELD_W = 2,
  parameter int IDX_W = 2,
  parameter clksel_pkg::enc_e ENC = clksel_pkg::ENC_INDEX0,
  parameter bit HIWORD_MASK = 1'b1,
  parameter logic [NUM_SRC*FIELD_W-1:0] MAP = '0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [31:0]          wrData,
  input  logic [NUM_SRC-1:0]   actMask,
  output logic [31:0]          regData,
  output logic [IDX_W-1:0]     selIdx,
  output logic                 busy,
  output logic                 selErr,
  output clksel_pkg::swCmd_t   cmd
);

  logic [31:0]        regQ;
  logic [31:0]        nextReg;
  logic [IDX_W-1:0]   tgtQ;
  logic               errQ;
  logic               decHit;
  logic [IDX_W-1:0]   decIdx;

  generate
    if (HIWORD_MASK) begin : g_mask
      assign nextReg = {16'h0000,
                        (regQ[15:0] & ~wrData[31:16]) | (wrData[15:0] & wrData[31:16])};
    end else begin : g_full
      assign nextReg = wrData;
    end
  endgenerate

  clksel_decode #(
    .NUM_SRC(NUM_SRC), .FIELD_W(FIELD_W), .IDX_W(IDX_W), .ENC(ENC), .MAP(MAP)
  ) uDecode (
    .field(nextReg[FIELD_LSB +: FIELD_W]),
    .hit(decHit),
    .idx(decIdx)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regQ <= '0;
      tgtQ <= '0;
      errQ <= 1'b0;
    end else if (wrEn) begin
      regQ <= nextReg;
      if (decHit) tgtQ <= decIdx;
      else        errQ <= 1'b1;
    end
  end

  always_comb begin
    cmd.want = clksel_pkg::MAX_SRC'(1) << tgtQ;
  end

  assign regData = regQ;
  assign selIdx  = tgtQ;
  assign selErr  = errQ;
  assign busy    = actMask != cmd.want[NUM_SRC-1:0];

  // R3: selection moves only on a write
  a_r3_sel_hold: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(tgtQ));

  // R7: undecodable value keeps the selection
  a_r7_bad_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !decHit) |=> $stable(tgtQ));

  // R7: error flag is sticky
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    selErr |=> selErr);

  // R10: a changing selection raises busy in the next cycle
  a_r10_busy_rise: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && decHit && (decIdx != tgtQ)) |=> busy);

  generate
    if (HIWORD_MASK) begin : g_maskChk
      // R5: bits whose enable was 0 keep their value
      a_r5_mask_keep: assert property (@(posedge clk) disable iff (!rstN)
        wrEn |=> (((regQ[15:0] ^ $past(regQ[15:0])) & ~$past(wrData[31:16])) == 16'h0000));
    end
  endgenerate

endmodule

// File: rtl/clksel_switch.sv
`timescale 1ns/1ps
module clksel_switch #(
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcClk,
  input  clksel_pkg::swCmd_t cmd,
  output logic [NUM_SRC-1:0] actMask,
  output logic               clkOut
);

  logic [NUM_SRC-1:0] enVec;
  logic [NUM_SRC-1:0] syncA;
  logic [NUM_SRC-1:0] syncB;
  logic               unusedWant;

  assign unusedWant = ^cmd.want;

  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      localparam logic [1:0] RST_VAL = (g == 0) ? 2'b11 : 2'b00;
      logic [1:0] stg;
      logic       othersOn;

      assign othersOn = |(enVec & ~(NUM_SRC'(1) << g));

      // enable chain clocked on the falling edge of its own parent
      always_ff @(negedge srcClk[g] or negedge rstN) begin
        if (!rstN) stg <= RST_VAL;
        else       stg <= {stg[0], cmd.want[g] & ~othersOn};
      end

      assign enVec[g] = stg[1];
    end
  endgenerate

  // bring the enable set back into the system clock domain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= NUM_SRC'(1);
      syncB <= NUM_SRC'(1);
    end else begin
      syncA <= enVec;
      syncB <= syncA;
    end
  end

  assign actMask = syncB;
  assign clkOut  = |(srcClk & enVec);

  // R8: never two parents enabled together
  always_comb begin
    if (rstN) begin
      a_r8_single_source: assert ($onehot0(enVec));
    end
  end

  // R10: completion indication is a single parent or none
  a_r10_act_single: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(actMask));

endmodule

// File: rtl/clksel_top.sv
`timescale 1ns/1ps
module clksel_top #(
  parameter int NUM_SRC = 4,
  parameter int FIELD_LSB = 14,
  parameter int FIELD_W = 2,
  parameter clksel_pkg::enc_e ENC = clksel_pkg::ENC_INDEX0,
  parameter bit HIWORD_MASK = 1'b1,
  parameter logic [NUM_SRC*FIELD_W-1:0] MAP = '0,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcClk,
  input  logic               wrEn,
  input  logic [31:0]        wrData,
  output logic [31:0]        regData,
  output logic [IDX_W-1:0]   selIdx,
  output logic               busy,
  output logic               selErr,
  output logic               clkOut
);

  clksel_pkg::swCmd_t cmd;
  logic [NUM_SRC-1:0] actMask;

  clksel_ctrl #(
    .NUM_SRC(NUM_SRC), .FIELD_LSB(FIELD_LSB), .FIELD_W(FIELD_W), .IDX_W(IDX_W),
    .ENC(ENC), .HIWORD_MASK(HIWORD_MASK), .MAP(MAP)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .actMask(actMask),
    .regData(regData), .selIdx(selIdx), .busy(busy), .selErr(selErr), .cmd(cmd)
  );

  clksel_switch #(
    .NUM_SRC(NUM_SRC)
  ) uSwitch (
    .clk(clk), .rstN(rstN), .srcClk(srcClk), .cmd(cmd),
    .actMask(actMask), .clkOut(clkOut)
  );

endmodule

// File: tb/clksel_top_test.sv
`timescale 1ns/1ps
module clksel_top_test;
  import clksel_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  srcClk = 4'b0000;
  logic [3:0]  wrEnV = 4'b0000;
  logic [31:0] wrDataV [4];
  logic [31:0] regDataV [4];
  logic [1:0]  selIdxV [4];
  logic [3:0]  busyV;
  logic [3:0]  errV;
  logic [3:0]  clkOutV;

  int total = 0;
  int bad = 0;

  // per-instance configuration seen by the bench model
  int cfgLsb [4] = '{14, 4, 8, 0};
  int cfgFw  [4] = '{2, 3, 4, 3};
  int cfgHi  [4] = '{1, 0, 1, 0};
  int cfgN   [4] = '{3, 4, 4, 4};
  int tabVal [4] = '{5, 2, 7, 2};
  int halfNs [4] = '{3, 7, 11, 17};

  logic [31:0] expReg [4];
  int          expIdx [4];
  bit          expErr [4];

  always #5 clk = ~clk;
  always #3 srcClk[0] = ~srcClk[0];
  always #7 srcClk[1] = ~srcClk[1];
  always #11 srcClk[2] = ~srcClk[2];
  always #17 srcClk[3] = ~srcClk[3];

  clksel_top #(.NUM_SRC(3), .FIELD_LSB(14), .FIELD_W(2), .ENC(ENC_INDEX0),
               .HIWORD_MASK(1'b1)) uut (
    .clk(clk), .rstN(rstN), .srcClk(srcClk[2:0]), .wrEn(wrEnV[0]), .wrData(wrDataV[0]),
    .regData(regDataV[0]), .selIdx(selIdxV[0]), .busy(busyV[0]), .selErr(errV[0]),
    .clkOut(clkOutV[0]));

  clksel_top #(.NUM_SRC(4), .FIELD_LSB(4), .FIELD_W(3), .ENC(ENC_INDEX1),
               .HIWORD_MASK(1'b0)) uutOne (
    .clk(clk), .rstN(rstN), .srcClk(srcClk), .wrEn(wrEnV[1]), .wrData(wrDataV[1]),
    .regData(regDataV[1]), .selIdx(selIdxV[1]), .busy(busyV[1]), .selErr(errV[1]),
    .clkOut(clkOutV[1]));

  clksel_top #(.NUM_SRC(4), .FIELD_LSB(8), .FIELD_W(4), .ENC(ENC_ONEHOT),
               .HIWORD_MASK(1'b1)) uutHot (
    .clk(clk), .rstN(rstN), .srcClk(srcClk), .wrEn(wrEnV[2]), .wrData(wrDataV[2]),
    .regData(regDataV[2]), .selIdx(selIdxV[2]), .busy(busyV[2]), .selErr(errV[2]),
    .clkOut(clkOutV[2]));

  clksel_top #(.NUM_SRC(4), .FIELD_LSB(0), .FIELD_W(3), .ENC(ENC_TABLE),
               .HIWORD_MASK(1'b0), .MAP({3'd2, 3'd7, 3'd2, 3'd5})) uutTab (
    .clk(clk), .rstN(rstN), .srcClk(srcClk), .wrEn(wrEnV[3]), .wrData(wrDataV[3]),
    .regData(regDataV[3]), .selIdx(selIdxV[3]), .busy(busyV[3]), .selErr(errV[3]),
    .clkOut(clkOutV[3]));

  // shortest pulse seen on each output after reset (R8)
  for (genvar k = 0; k < 4; k++) begin : mon
    realtime lastT = 0.0;
    realtime shortest = 1.0e9;
    always @(clkOutV[k]) begin
      if (rstN && lastT > 0.0 && ($realtime - lastT) < shortest)
        shortest = $realtime - lastT;
      lastT = $realtime;
    end
  end

  task automatic chkEq(input string tag, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic chkMin(input string tag, input string what, input longint act, input longint lim);
    total++;
    if (act < lim) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected>=%0d", tag, what, act, lim);
    end
  endtask

  function automatic int refDecode(input int u, input int v);
    int n = cfgN[u];
    case (u)
      0: return (v < n) ? v : -1;
      1: return (v >= 1 && v <= n) ? v - 1 : -1;
      2: begin
        if ($countones(v) != 1) return -1;
        for (int i = 0; i < n; i++) if (v == (1 << i)) return i;
        return -1;
      end
      default: begin
        for (int i = 0; i < n; i++) if (v == tabVal[i]) return i;
        return -1;
      end
    endcase
  endfunction

  task automatic measurePeriod(input int u, input string tag);
    realtime t0, t1;
    wait (clkOutV[u] == 1'b0);
    wait (clkOutV[u] == 1'b1);
    t0 = $realtime;
    wait (clkOutV[u] == 1'b0);
    wait (clkOutV[u] == 1'b1);
    t1 = $realtime;
    chkEq(tag, "clkOut period ps", longint'((t1 - t0) * 1000.0),
          longint'(2 * halfNs[expIdx[u]] * 1000));
  endtask

  task automatic stepWrite(input int u, input logic [31:0] d);
    logic [31:0] nr;
    int fld, dec, prev;
    if (cfgHi[u] != 0)
      nr = {16'h0000, (expReg[u][15:0] & ~d[31:16]) | (d[15:0] & d[31:16])};
    else
      nr = d;
    fld = int'((nr >> cfgLsb[u]) & ((32'd1 << cfgFw[u]) - 32'd1));
    dec = refDecode(u, fld);
    prev = expIdx[u];
    expReg[u] = nr;
    if (dec >= 0) expIdx[u] = dec;
    else          expErr[u] = 1'b1;
    @(negedge clk);
    wrEnV[u] = 1'b1;
    wrDataV[u] = d;
    @(negedge clk);
    wrEnV[u] = 1'b0;
    chkEq("R3/R5", "regData", regDataV[u], expReg[u]);
    chkEq((u == 0) ? "R2" : (u == 1) ? "R4" : (u == 2) ? "R6" : "R11",
          "selIdx", selIdxV[u], expIdx[u]);
    chkEq("R7", "selErr", errV[u], expErr[u]);
    chkEq("R10", "busy after write", busyV[u], (expIdx[u] != prev) ? 1 : 0);
    for (int c = 0; c < 400; c++) begin
      if (!busyV[u]) break;
      @(negedge clk);
    end
    chkEq("R10", "busy cleared", busyV[u], 0);
    measurePeriod(u, "R9");
  endtask

  task automatic finishRun;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #1500000;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    logic [31:0] d, fmask, filler;
    for (int u = 0; u < 4; u++) begin
      wrDataV[u] = '0;
      expReg[u] = '0;
      expIdx[u] = 0;
      expErr[u] = 1'b0;
    end
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state of every instance
    for (int u = 0; u < 4; u++) begin
      chkEq("R1", "regData", regDataV[u], 0);
      chkEq("R1", "selIdx", selIdxV[u], 0);
      chkEq("R1", "busy", busyV[u], 0);
      chkEq("R1", "selErr", errV[u], 0);
    end
    measurePeriod(0, "R1");
    measurePeriod(3, "R1");

    // sweep every field value of every configuration
    for (int u = 0; u < 4; u++) begin
      fmask = ((32'd1 << cfgFw[u]) - 32'd1) << cfgLsb[u];
      for (int v = 0; v < (1 << cfgFw[u]); v++) begin
        filler = 32'h9C6B_E3D1 ^ (32'(v) * 32'h0011_0101);
        d = (filler & ~fmask) | (32'(v) << cfgLsb[u]);
        if (cfgHi[u] != 0) d = {16'hFFFF, d[15:0]};
        stepWrite(u, d);
      end
    end

    // R5: partial masks on the masked instances
    stepWrite(0, 32'h00FF_5AC3);   // field bits not enabled: selection kept
    stepWrite(0, 32'h4000_4000);   // enable only bit 14
    stepWrite(0, 32'hC000_4000);   // write field to 1
    stepWrite(2, 32'h0F00_0400);   // one-hot field -> parent 2
    stepWrite(2, 32'h0100_0100);   // adds bit 8: two bits set, invalid
    stepWrite(2, 32'h0400_0000);   // clear bit 10: one-hot parent 0
    stepWrite(1, 32'hFFFF_FF3F);   // full-word write, field 3 -> parent 2

    // R8: no short pulse on any output
    chkMin("R8", "uut min pulse ps", longint'(mon[0].shortest * 1000.0), 2900);
    chkMin("R8", "uutOne min pulse ps", longint'(mon[1].shortest * 1000.0), 2900);
    chkMin("R8", "uutHot min pulse ps", longint'(mon[2].shortest * 1000.0), 2900);
    chkMin("R8", "uutTab min pulse ps", longint'(mon[3].shortest * 1000.0), 2900);

    finishRun();
  end

endmodule